// File: doc/BRIEF.md
# Transmit descriptor ring walker

The engine walks a list of transmit descriptors kept in system memory. Each descriptor has four 32-bit words: status, control/size, buffer address and next-descriptor address. A single-cycle poll strobe wakes the engine. The engine then reads the status word at its current pointer. If the hardware ownership flag in that word is clear, the engine goes back to sleep on that same descriptor. If the flag is set, the engine reads the remaining three words. It then hands the buffer address and byte count to a frame sender, waits for the sender to report completion, and writes the status word back with ownership released and the error flag updated. Finally it moves to the next descriptor and reads that one straight away.

Setup frames are reported on a separate output and never reach the frame sender. There are three ways to find the next descriptor: an explicit chained pointer, a wrap to the ring base, or the adjacent slot 16 bytes further on. Software sets the ring base through a write strobe and sees only a running/suspended flag. Memory is reached one word per access through a valid/ready request channel. Each read returns one response beat, and writes have no response.

Back-pressure rules are the same on all three outgoing channels (memory request, transfer request, setup report). Once valid is raised, it and the payload stay fixed until the cycle in which ready is high. The transfer is made in that cycle.

Top module: `tde_engine`

## Requirements
- R1: After reset the engine is suspended: `running` is 0, and `mem_req_valid`, `xfer_valid` and `setup_valid` are all 0.
- R2: A poll strobe while suspended starts a fetch. The engine reads the status word at the current pointer first. Only if that word has bit 31 (ownership) set does it read the words at pointer+4, +8 and +12, in that order.
- R3: If the fetched status word has bit 31 clear, `running` drops and the engine issues no further request. The descriptor is not written. The engine stays suspended on that pointer until the next poll strobe.
- R4: For an owned descriptor with control bit 27 clear, the engine presents one transfer request. Its address is word 2, its length is control bits 10:0, its first flag is control bit 29 and its last flag is control bit 30. The request is held stable until `xfer_ready`.
- R5: After a transfer, the status write waits for the `tx_done` pulse. It goes to the descriptor's own address. The value written is the fetched status word with bit 31 cleared and bit 15 equal to `tx_err`; all other bits are kept.
- R6: An owned descriptor with control bit 27 set is reported on the setup channel (word 2 and control bits 10:0) and never on the transfer channel. Its status is written back with bits 31 and 15 cleared, and the engine does not wait for `tx_done`.
- R7: After the write-back, the next pointer is chosen in this order. If control bit 24 is set, the pointer is word 3. Otherwise, if control bit 25 is set, it is the ring base. Otherwise it is the current pointer plus 16.
- R8: A base write while suspended moves the current pointer to the new base. A base write while running leaves the current pointer alone but changes the base used for later wraps.
- R9: A poll strobe while running has no effect on the sequence of memory, transfer and setup requests.
- R10: A memory request that is not accepted keeps `mem_req_valid`, `mem_req_we`, `mem_req_addr` and `mem_req_wdata` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Ring base write strobe |
| base_wdata | input | ADDR_W | New ring base byte address |
| poll_req | input | 1 | Poll demand, one cycle |
| running | output | 1 | 1 while walking, 0 while suspended |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word byte address |
| mem_req_wdata | output | 32 | Write data (status write-back) |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Transfer request accepted |
| xfer_addr | output | ADDR_W | Frame buffer address |
| xfer_len | output | 11 | Frame byte count |
| xfer_first | output | 1 | First segment flag |
| xfer_last | output | 1 | Last segment flag |
| tx_done | input | 1 | Sender completion pulse |
| tx_err | input | 1 | Error flag, valid with `tx_done` |
| setup_valid | output | 1 | Setup frame report valid |
| setup_ready | input | 1 | Setup frame report accepted |
| setup_addr | output | ADDR_W | Setup frame buffer address |
| setup_len | output | 11 | Setup frame byte count |

## Verification
The properties assume three things about the environment. The memory returns exactly one response beat for each accepted read and none for writes. The sender pulses `tx_done` once, and only after it has accepted a transfer request. Software changes descriptors only while `running` is low. The bench's memory and sender stubs keep to this by construction. They answer a read one cycle after it is accepted, and they hold off `mem_req_ready`, `xfer_ready` and `setup_ready` in fixed periodic patterns so that held requests occur. Descriptor rewrites happen only after the engine has been seen suspended and the expected event queue is empty.

// File: rtl/tde_pkg.sv
package tde_pkg;
  localparam int WORD_W      = 32;
  localparam int DESC_WORDS  = 4;
  localparam int IDX_W       = $clog2(DESC_WORDS);
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int WORD_SHIFT  = $clog2(WORD_BYTES);
  localparam int DESC_BYTES  = DESC_WORDS * WORD_BYTES;
  localparam int LEN_W       = 11;

  // status word
  localparam int OWN_BIT      = 31;
  localparam int ERR_BIT      = 15;
  // control word
  localparam int LAST_BIT     = 30;
  localparam int FIRST_BIT    = 29;
  localparam int SETUP_BIT    = 27;
  localparam int RING_END_BIT = 25;
  localparam int CHAIN_BIT    = 24;

  // word positions inside a descriptor
  localparam int STATUS_IDX = 0;
  localparam int CTRL_IDX   = 1;
  localparam int BUF_IDX    = 2;
  localparam int NEXT_IDX   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_SETUP,
    ST_XFER,
    ST_DONE_WAIT,
    ST_WB_REQ
  } eng_state_t;
endpackage

// File: rtl/tde_desc_store.sv
module tde_desc_store
  import tde_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_en,
  input  logic [IDX_W-1:0]     cap_idx,
  input  logic [WORD_W-1:0]    cap_data,
  output logic [WORD_W-1:0]    status_word,
  output logic [LEN_W-1:0]     len,
  output logic                 first_seg,
  output logic                 last_seg,
  output logic                 setup_flag,
  output logic                 ring_end,
  output logic                 chained,
  output logic [ADDR_W-1:0]    buf_addr,
  output logic [ADDR_W-1:0]    next_addr
);
  logic                 sel_status, sel_ctrl, sel_buf, sel_next;

  assign sel_status = cap_en && (cap_idx == IDX_W'(STATUS_IDX));
  assign sel_ctrl   = cap_en && (cap_idx == IDX_W'(CTRL_IDX));
  assign sel_buf    = cap_en && (cap_idx == IDX_W'(BUF_IDX));
  assign sel_next   = cap_en && (cap_idx == IDX_W'(NEXT_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_word <= '0;
    end else if (sel_status) begin
      status_word <= cap_data;
    end
  end

  // only the control fields that are acted on are kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len        <= '0;
      first_seg  <= 1'b0;
      last_seg   <= 1'b0;
      setup_flag <= 1'b0;
      ring_end   <= 1'b0;
      chained    <= 1'b0;
    end else if (sel_ctrl) begin
      len        <= cap_data[LEN_W-1:0];
      first_seg  <= cap_data[FIRST_BIT];
      last_seg   <= cap_data[LAST_BIT];
      setup_flag <= cap_data[SETUP_BIT];
      ring_end   <= cap_data[RING_END_BIT];
      chained    <= cap_data[CHAIN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      next_addr <= '0;
    end else begin
      if (sel_buf)  buf_addr  <= cap_data[ADDR_W-1:0];
      if (sel_next) next_addr <= cap_data[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/tde_ptr_unit.sv
module tde_ptr_unit
  import tde_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              idle,
  input  logic              advance,
  input  logic              chained,
  input  logic              ring_end,
  input  logic [ADDR_W-1:0] chain_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] step_addr;

  // chained pointer wins over ring wrap, wrap wins over sequential step
  always_comb begin
    if (chained)       step_addr = chain_addr;
    else if (ring_end) step_addr = base_q;
    else               step_addr = cur_q + ADDR_W'(DESC_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur_q <= '0;
    else if (advance)          cur_q <= step_addr;
    else if (base_we && idle)  cur_q <= base_wdata;
  end

  assign cur_addr = cur_q;
endmodule

// File: rtl/tde_fsm.sv
module tde_fsm
  import tde_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_req,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic             rsp_own,
  input  logic             setup_flag,
  input  logic             xfer_ready,
  input  logic             setup_ready,
  input  logic             tx_done,
  input  logic             tx_err,
  output eng_state_t       state,
  output logic [IDX_W-1:0] word_idx,
  output logic             cap_en,
  output logic             advance,
  output logic             wb_err
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(STATUS_IDX);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DESC_WORDS - 1);

  eng_state_t       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (poll_req) begin
          state_d = ST_RD_REQ;
          idx_d   = FIRST_IDX;
        end
      end
      ST_RD_REQ: begin
        if (mem_req_ready) state_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          if (idx_q == FIRST_IDX && !rsp_own) begin
            state_d = ST_IDLE;
          end else if (idx_q == LAST_IDX) begin
            state_d = setup_flag ? ST_SETUP : ST_XFER;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = ST_RD_REQ;
          end
        end
      end
      ST_SETUP: begin
        if (setup_ready) begin
          err_d   = 1'b0;
          state_d = ST_WB_REQ;
        end
      end
      ST_XFER: begin
        if (xfer_ready) state_d = ST_DONE_WAIT;
      end
      ST_DONE_WAIT: begin
        if (tx_done) begin
          err_d   = tx_err;
          state_d = ST_WB_REQ;
        end
      end
      ST_WB_REQ: begin
        if (mem_req_ready) begin
          state_d = ST_RD_REQ;
          idx_d   = FIRST_IDX;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign state    = state_q;
  assign word_idx = idx_q;
  assign cap_en   = (state_q == ST_RD_WAIT) && mem_rsp_valid;
  assign advance  = (state_q == ST_WB_REQ) && mem_req_ready;
  assign wb_err   = err_q;
endmodule

// File: rtl/tde_engine.sv
module tde_engine
  import tde_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              poll_req,
  output logic              running,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [10:0]       xfer_len,
  output logic              xfer_first,
  output logic              xfer_last,
  input  logic              tx_done,
  input  logic              tx_err,
  output logic              setup_valid,
  input  logic              setup_ready,
  output logic [ADDR_W-1:0] setup_addr,
  output logic [10:0]       setup_len
);
  eng_state_t        state;
  logic [IDX_W-1:0]  word_idx;
  logic              cap_en, advance, wb_err;
  logic [WORD_W-1:0] status_word;
  logic [LEN_W-1:0]  len;
  logic              first_seg, last_seg, setup_flag, ring_end, chained;
  logic [ADDR_W-1:0] buf_addr, next_addr, cur_addr;
  logic [WORD_W-1:0] wb_word;
  logic              idle;

  assign idle = (state == ST_IDLE);

  tde_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .poll_req      (poll_req),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_own       (mem_rsp_data[OWN_BIT]),
    .setup_flag    (setup_flag),
    .xfer_ready    (xfer_ready),
    .setup_ready   (setup_ready),
    .tx_done       (tx_done),
    .tx_err        (tx_err),
    .state         (state),
    .word_idx      (word_idx),
    .cap_en        (cap_en),
    .advance       (advance),
    .wb_err        (wb_err)
  );

  tde_desc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_en      (cap_en),
    .cap_idx     (word_idx),
    .cap_data    (mem_rsp_data),
    .status_word (status_word),
    .len         (len),
    .first_seg   (first_seg),
    .last_seg    (last_seg),
    .setup_flag  (setup_flag),
    .ring_end    (ring_end),
    .chained     (chained),
    .buf_addr    (buf_addr),
    .next_addr   (next_addr)
  );

  tde_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .idle       (idle),
    .advance    (advance),
    .chained    (chained),
    .ring_end   (ring_end),
    .chain_addr (next_addr),
    .cur_addr   (cur_addr)
  );

  // status write-back: release ownership, report the sender's error
  always_comb begin
    wb_word          = status_word;
    wb_word[OWN_BIT] = 1'b0;
    wb_word[ERR_BIT] = wb_err;
  end

  assign running       = !idle;
  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB_REQ);
  assign mem_req_we    = (state == ST_WB_REQ);
  assign mem_req_addr  = (state == ST_WB_REQ) ? cur_addr
                         : cur_addr + (ADDR_W'(word_idx) << WORD_SHIFT);
  assign mem_req_wdata = wb_word;

  assign xfer_valid = (state == ST_XFER);
  assign xfer_addr  = buf_addr;
  assign xfer_len   = len;
  assign xfer_first = first_seg;
  assign xfer_last  = last_seg;

  assign setup_valid = (state == ST_SETUP);
  assign setup_addr  = buf_addr;
  assign setup_len   = len;
endmodule

// File: rtl/tde_engine_chk.sv
module tde_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_req,
  input logic              running,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [10:0]       xfer_len,
  input logic              xfer_first,
  input logic              xfer_last,
  input logic              setup_valid
);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
      && $stable(mem_req_addr) && $stable(mem_req_wdata));

  p_xfer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_len) && $stable(xfer_first) && $stable(xfer_last));

  p_setup_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_valid && xfer_valid));

  p_quiet_when_suspended_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !mem_req_valid && !xfer_valid && !setup_valid);

  p_wb_releases_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !mem_req_wdata[31]);

  p_poll_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running && poll_req |=> running && mem_req_valid && !mem_req_we);
endmodule

bind tde_engine tde_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .poll_req      (poll_req),
  .running       (running),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .xfer_valid    (xfer_valid),
  .xfer_ready    (xfer_ready),
  .xfer_addr     (xfer_addr),
  .xfer_len      (xfer_len),
  .xfer_first    (xfer_first),
  .xfer_last     (xfer_last),
  .setup_valid   (setup_valid)
);

// File: tb/tde_engine_tb.sv
module tde_engine_tb;
  localparam int AW = 32;
  localparam logic [31:0] OWN   = 32'h8000_0000;
  localparam logic [31:0] C_LS  = 32'h4000_0000;
  localparam logic [31:0] C_FS  = 32'h2000_0000;
  localparam logic [31:0] C_SET = 32'h0800_0000;
  localparam logic [31:0] C_EOR = 32'h0200_0000;
  localparam logic [31:0] C_CH  = 32'h0100_0000;
  localparam logic [31:0] ERR_BUF = 32'h0000_3400;

  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_XF = 2'd2, K_SU = 2'd3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
  } ev_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, base_we, poll_req;
  logic [AW-1:0] base_wdata;
  logic          running;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [31:0]   mem_req_wdata;
  logic          mem_rsp_valid;
  logic [31:0]   mem_rsp_data;
  logic          xfer_valid, xfer_ready, xfer_first, xfer_last;
  logic [AW-1:0] xfer_addr;
  logic [10:0]   xfer_len;
  logic          tx_done, tx_err;
  logic          setup_valid, setup_ready;
  logic [AW-1:0] setup_addr;
  logic [10:0]   setup_len;

  tde_engine #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .poll_req(poll_req), .running(running),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .xfer_valid(xfer_valid),
    .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_first(xfer_first), .xfer_last(xfer_last), .tx_done(tx_done),
    .tx_err(tx_err), .setup_valid(setup_valid), .setup_ready(setup_ready),
    .setup_addr(setup_addr), .setup_len(setup_len)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory images: stub side and model side ----------------
  logic [31:0] mem     [int];
  logic [31:0] ref_mem [int];

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (mem.exists(int'(a >> 2))) return mem[int'(a >> 2)];
    return 32'h0;
  endfunction

  function automatic logic [31:0] rd_ref(input logic [31:0] a);
    if (ref_mem.exists(int'(a >> 2))) return ref_mem[int'(a >> 2)];
    return 32'h0;
  endfunction

  task automatic sw_write(input logic [31:0] a, input logic [31:0] d);
    mem[int'(a >> 2)]     = d;
    ref_mem[int'(a >> 2)] = d;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] st,
                          input logic [31:0] ct, input logic [31:0] bf,
                          input logic [31:0] nx);
    sw_write(a, st); sw_write(a + 4, ct); sw_write(a + 8, bf); sw_write(a + 12, nx);
  endtask

  // ---------------- stubs: memory and frame sender ----------------
  int cyc;
  int tx_cnt;
  logic pend_err;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
      xfer_ready <= 1'b0; setup_ready <= 1'b0; tx_done <= 1'b0; tx_err <= 1'b0;
      tx_cnt <= 0; pend_err <= 1'b0;
    end else begin
      cyc           <= cyc + 1;
      mem_req_ready <= (cyc % 3) != 1;
      xfer_ready    <= (cyc % 4) == 2;
      setup_ready   <= (cyc % 2) == 0;
      mem_rsp_valid <= 1'b0;
      tx_done       <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) mem[int'(mem_req_addr >> 2)] = mem_req_wdata;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd_mem(mem_req_addr);
        end
      end
      if (xfer_valid && xfer_ready) begin
        tx_cnt   <= 3;
        pend_err <= (xfer_addr == ERR_BUF);
      end else if (tx_cnt > 0) begin
        tx_cnt <= tx_cnt - 1;
        if (tx_cnt == 1) begin
          tx_done <= 1'b1;
          tx_err  <= pend_err;
        end
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  ev_t         exp_q[$];
  logic [31:0] ref_base = '0;
  logic [31:0] ref_cur  = '0;

  task automatic push(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    e.kind = k; e.addr = a; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic model_walk();
    for (int n = 0; n < 64; n++) begin
      logic [31:0] st, ct, bf, nx, wb;
      logic err;
      push(K_RD, ref_cur, 0);
      st = rd_ref(ref_cur);
      if (!st[31]) break;
      push(K_RD, ref_cur + 4, 0);
      push(K_RD, ref_cur + 8, 0);
      push(K_RD, ref_cur + 12, 0);
      ct = rd_ref(ref_cur + 4);
      bf = rd_ref(ref_cur + 8);
      nx = rd_ref(ref_cur + 12);
      if (ct[27]) begin
        push(K_SU, bf, {21'd0, ct[10:0]});
        err = 1'b0;
      end else begin
        push(K_XF, bf, {14'd0, ct[30], ct[29], 5'd0, ct[10:0]});
        err = (bf == ERR_BUF);
      end
      wb = st;
      wb[31] = 1'b0;
      wb[15] = err;
      push(K_WR, ref_cur, wb);
      ref_mem[int'(ref_cur >> 2)] = wb;
      if (ct[24])      ref_cur = nx;
      else if (ct[25]) ref_cur = ref_base;
      else             ref_cur = ref_cur + 16;
    end
  endtask

  // ---------------- monitor: compare every clock ----------------
  int          seen_events;
  logic [31:0] last_rd_addr;
  logic        hold_mem, hold_xf;
  logic [64:0] hold_mem_val;
  logic [44:0] hold_xf_val;

  task automatic observe(input logic [1:0] k, input logic [31:0] a, input logic [31:0] d);
    ev_t   e;
    string req;
    seen_events++;
    case (k)
      K_RD:    req = "R2/R7";
      K_WR:    req = "R5";
      K_XF:    req = "R4";
      default: req = "R6";
    endcase
    if (exp_q.size() == 0) begin
      check(1'b0, {req, " unexpected event"}, {30'd0, k, a}, 64'd0);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == k && e.addr == a && e.data == d, req,
          {k, a, d[29:0]}, {e.kind, e.addr, e.data[29:0]});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_mem)
        check(mem_req_valid && {mem_req_we, mem_req_addr, mem_req_wdata} == hold_mem_val,
              "R10 request held", {63'd0, mem_req_valid}, 64'd1);
      if (hold_xf)
        check(xfer_valid && {xfer_addr, xfer_len, xfer_first, xfer_last} == hold_xf_val,
              "R4 transfer held", {63'd0, xfer_valid}, 64'd1);
      hold_mem     = mem_req_valid && !mem_req_ready;
      hold_mem_val = {mem_req_we, mem_req_addr, mem_req_wdata};
      hold_xf      = xfer_valid && !xfer_ready;
      hold_xf_val  = {xfer_addr, xfer_len, xfer_first, xfer_last};
      if (mem_req_valid && mem_req_ready) begin
        if (!mem_req_we) last_rd_addr = mem_req_addr;
        observe(mem_req_we ? K_WR : K_RD, mem_req_addr, mem_req_we ? mem_req_wdata : 32'd0);
      end
      if (xfer_valid && xfer_ready)
        observe(K_XF, xfer_addr, {14'd0, xfer_last, xfer_first, 5'd0, xfer_len});
      if (setup_valid && setup_ready)
        observe(K_SU, setup_addr, {21'd0, setup_len});
    end else begin
      hold_mem = 1'b0;
      hold_xf  = 1'b0;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_poll();
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
  endtask

  task automatic poll_and_model();
    model_walk();
    pulse_poll();
  endtask

  task automatic write_base(input logic [31:0] b, input bit engine_idle);
    @(negedge clk); base_we = 1'b1; base_wdata = b;
    @(negedge clk); base_we = 1'b0;
    ref_base = b;
    if (engine_idle) ref_cur = b;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!running && exp_q.size() == 0) break;
    end
    check(!running && exp_q.size() == 0, req, {63'd0, running}, 64'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    seen_events  = 0;
    last_rd_addr = '0;
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0; poll_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1: suspended and quiet out of reset
    check(!running && !mem_req_valid && !xfer_valid && !setup_valid, "R1 reset state",
          {60'd0, running, mem_req_valid, xfer_valid, setup_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!running, "R1 idle after release", {63'd0, running}, 64'd0);

    // ring: chained, setup, sequential, wrap to base
    put_desc(32'h100, OWN,                C_FS | C_LS | C_CH | 32'd60, 32'h2000, 32'h200);
    put_desc(32'h200, OWN,                C_SET | C_CH | 32'd192,      32'h3000, 32'h140);
    put_desc(32'h140, OWN | 32'h0000_0123, C_FS | 32'd100,             ERR_BUF,  32'h0);
    put_desc(32'h150, OWN | 32'h0000_8005, C_LS | C_EOR | 32'd7,       32'h3800, 32'h0);
    write_base(32'h100, 1'b1);
    poll_and_model();
    wait_idle("R3 suspended after ring walk");
    check(rd_mem(32'h140) == 32'h0000_8123, "R5 error written back",
          {32'd0, rd_mem(32'h140)}, 64'h8123);
    check(rd_mem(32'h150) == 32'h0000_0005, "R5 error cleared on good frame",
          {32'd0, rd_mem(32'h150)}, 64'h5);
    check(rd_mem(32'h200) == 32'h0, "R6 setup write-back",
          {32'd0, rd_mem(32'h200)}, 64'h0);
    check(last_rd_addr == 32'h100, "R7 wrapped to base",
          {32'd0, last_rd_addr}, 64'h100);

    // R3: no activity while suspended, descriptor untouched
    seen_events = 0;
    repeat (25) @(negedge clk);
    check(seen_events == 0 && !running, "R3 stays suspended",
          {32'd0, 32'(seen_events)}, 64'd0);
    check(rd_mem(32'h100) == 32'h0, "R3 unowned status not written",
          {32'd0, rd_mem(32'h100)}, 64'd0);

    // R9: re-arm first descriptor, poll again mid-walk
    sw_write(32'h100, OWN | 32'h0000_0040);
    model_walk();
    pulse_poll();
    repeat (6) @(negedge clk);
    poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    repeat (9) @(negedge clk);
    poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    wait_idle("R9 poll while running ignored");
    check(last_rd_addr == 32'h200, "R9 stopped on next unowned",
          {32'd0, last_rd_addr}, 64'h200);
    check(rd_mem(32'h100) == 32'h0000_0040, "R5 other status bits kept",
          {32'd0, rd_mem(32'h100)}, 64'h40);

    // R8: base write while suspended moves the pointer
    sw_write(32'h400, 32'h0);
    write_base(32'h400, 1'b1);
    poll_and_model();
    wait_idle("R8 idle base write");
    check(last_rd_addr == 32'h400, "R8 pointer moved to new base",
          {32'd0, last_rd_addr}, 64'h400);

    // R8: base write while running only changes the wrap target
    put_desc(32'h400, OWN, C_FS | C_LS | C_EOR | 32'd20, 32'h4000, 32'h0);
    sw_write(32'h500, 32'h0);
    ref_base = 32'h500;
    model_walk();
    pulse_poll();
    @(negedge clk); base_we = 1'b1; base_wdata = 32'h500;
    @(negedge clk); base_we = 1'b0;
    wait_idle("R8 running base write");
    check(last_rd_addr == 32'h500, "R8 wrap used new base",
          {32'd0, last_rd_addr}, 64'h500);
    check(rd_mem(32'h400) == 32'h0, "R5 owner released",
          {32'd0, rd_mem(32'h400)}, 64'd0);

    // R7: sequential step without chain or wrap
    put_desc(32'h500, OWN, C_FS | 32'd33, 32'h5000, 32'hdead_0000);
    sw_write(32'h510, 32'h0);
    poll_and_model();
    wait_idle("R7 sequential walk");
    check(last_rd_addr == 32'h510, "R7 step of 16 bytes",
          {32'd0, last_rd_addr}, 64'h510);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected events seen",
          {32'd0, 32'(exp_q.size())}, 64'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule